// File: doc/BRIEF.md
# Saturating Receive Error Counter Bank

This block gathers receive statistics for a network receiver. It has a bank of narrow error counters and one wider byte counter that measures the length of the current frame. Each error counter advances on a single-cycle event pulse from the receive logic. A counter stops at its top value rather than wrapping, so a long run of errors is never reported as a small number. Software reads a counter through a select and read-enable pair, and that read clears the counter, so every read returns the errors seen since the previous read.

A shared interrupt request stays high while any error counter sits at or above a warning level (192 by default). This lets software drain the counters before they saturate. The byte counter follows frame boundaries. It restarts at the first byte of a frame, counts every byte up to and including the last, and then holds its value so the frame length can be written into a status record. Reading the byte counter does not clear it. Deciding what counts as an error is left to the logic that drives the event inputs.

Top module: `rx_stat_counters`

## Requirements
- R1: Each cycle in which `err_evt_i[k]` is high, with counter k not selected for a read and below its maximum, counter k rises by exactly one.
- R2: An error counter at 255 stays at 255 on further events and never wraps to zero.
- R3: `rd_data_o` shows the selected counter combinationally, whether or not `rd_en_i` is high. Select codes 0, 1 and 2 pick error counters 0 to 2, and code 3 picks the byte counter. Error counter values are zero-extended in bits 15:8. A cycle with `rd_en_i` high and an error counter selected leaves that counter at zero afterwards.
- R4: When a read and an event hit the same error counter in the same cycle, the read returns the old value and the counter continues from 1.
- R5: `irq_o` is high exactly while at least one error counter holds a value of 192 or more. It returns low once every counter is below 192.
- R6: A cycle with `sof_i` high restarts the byte counter. Every byte strobe from that cycle up to and including the `eof_i` cycle is counted. Reading with select code 3 does not clear the byte counter.
- R7: After `eof_i`, the byte counter holds its value, and byte strobes outside a frame are ignored.
- R8: The byte counter stops at 65535.
- R9: An event or read on one error counter leaves the other error counters unchanged. Simultaneous events on several counters each count.
- R10: After reset, every counter reads zero and `irq_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| err_evt_i | input | 3 | One event pulse per error counter |
| byte_vld_i | input | 1 | One received byte this cycle |
| sof_i | input | 1 | First cycle of a frame |
| eof_i | input | 1 | Last cycle of a frame |
| rd_en_i | input | 1 | Read strobe; clears the selected error counter |
| rd_sel_i | input | 2 | Counter select: 0 to 2 error counters, 3 byte counter |
| rd_data_o | output | 16 | Value of the selected counter |
| irq_o | output | 1 | High while any error counter is at or above 192 |

## Verification
The assertions assume that an event input is a clean level sampled once per clock. They also assume that a read strobe is always paired with a stable select in the same cycle, and that `sof_i` and `eof_i` mark sensible frame bounds. The bench keeps to these rules. It changes every input only on the falling edge, holds each read for exactly one cycle, and keeps frames well formed. The only exception is deliberate strobes outside a frame, which probe the ignore rule. Values are observed through the select with the read strobe low, so observing a counter never disturbs it.

// File: rtl/rx_stat_pkg.sv
package rx_stat_pkg;
  localparam int unsigned DEF_ERR_W  = 8;
  localparam int unsigned DEF_BYTE_W = 16;
  localparam int unsigned DEF_NUM    = 3;
  localparam int unsigned DEF_WARN   = 192;

  typedef enum logic {BC_IDLE = 1'b0, BC_FRAME = 1'b1} bc_state_e;
endpackage

// File: rtl/sat_err_counter.sv
module sat_err_counter #(
  parameter int unsigned W    = 8,
  parameter int unsigned WARN = 192
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         evt_i,
  input  logic         clr_i,
  output logic [W-1:0] cnt_o,
  output logic         warn_o
);
  localparam logic [W-1:0] MAX_V  = {W{1'b1}};
  localparam logic [W-1:0] WARN_V = W'(WARN);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (clr_i)            cnt_q <= evt_i ? W'(1) : '0;
    else if (evt_i && cnt_q != MAX_V) cnt_q <= cnt_q + W'(1);
  end

  assign cnt_o  = cnt_q;
  assign warn_o = (cnt_q >= WARN_V);

  p_step_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i && !clr_i && cnt_q != MAX_V) |=> cnt_q == $past(cnt_q) + W'(1));
  p_sat_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == MAX_V && !clr_i) |=> cnt_q == MAX_V);
  p_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !evt_i) |=> cnt_q == '0);
  p_rd_evt_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && evt_i) |=> cnt_q == W'(1));
endmodule

// File: rtl/rx_byte_counter.sv
module rx_byte_counter
  import rx_stat_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         byte_vld_i,
  input  logic         sof_i,
  input  logic         eof_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] MAX_V = {W{1'b1}};

  bc_state_e    state_q;
  logic [W-1:0] cnt_q;
  logic         cnt_en;

  assign cnt_en = byte_vld_i && (state_q == BC_FRAME);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= BC_IDLE;
    end else if (sof_i && !eof_i) begin
      state_q <= BC_FRAME;
    end else if (eof_i) begin
      state_q <= BC_IDLE;
    end
  end

  // sof restarts the count; the sof byte itself is counted
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          cnt_q <= '0;
    else if (sof_i)                       cnt_q <= byte_vld_i ? W'(1) : '0;
    else if (cnt_en && cnt_q != MAX_V)    cnt_q <= cnt_q + W'(1);
  end

  assign cnt_o = cnt_q;

  p_sof_restart_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sof_i && byte_vld_i) |=> cnt_q == W'(1));
  p_idle_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == BC_IDLE && !sof_i) |=> $stable(cnt_q));
  p_sat_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == MAX_V && !sof_i) |=> cnt_q == MAX_V);
endmodule

// File: rtl/warn_irq_gen.sv
module warn_irq_gen #(
  parameter int unsigned N = 3
) (
  input  logic [N-1:0] warn_i,
  output logic         irq_o
);
  assign irq_o = |warn_i;
endmodule

// File: rtl/rx_stat_counters.sv
module rx_stat_counters
  import rx_stat_pkg::*;
#(
  parameter int unsigned ERR_W   = DEF_ERR_W,
  parameter int unsigned BYTE_W  = DEF_BYTE_W,
  parameter int unsigned NUM_ERR = DEF_NUM,
  parameter int unsigned WARN    = DEF_WARN,
  localparam int unsigned SEL_W  = $clog2(NUM_ERR + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_ERR-1:0] err_evt_i,
  input  logic               byte_vld_i,
  input  logic               sof_i,
  input  logic               eof_i,
  input  logic               rd_en_i,
  input  logic [SEL_W-1:0]   rd_sel_i,
  output logic [BYTE_W-1:0]  rd_data_o,
  output logic               irq_o
);
  localparam logic [SEL_W-1:0] BYTE_SEL = SEL_W'(NUM_ERR);

  logic [ERR_W-1:0]   err_cnt [NUM_ERR];
  logic [NUM_ERR-1:0] warn;
  logic [NUM_ERR-1:0] clr;
  logic [BYTE_W-1:0]  byte_cnt;

  for (genvar k = 0; k < NUM_ERR; k++) begin : g_err
    assign clr[k] = rd_en_i && (rd_sel_i == SEL_W'(k));

    sat_err_counter #(.W(ERR_W), .WARN(WARN)) u_cnt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .evt_i  (err_evt_i[k]),
      .clr_i  (clr[k]),
      .cnt_o  (err_cnt[k]),
      .warn_o (warn[k])
    );

    p_isolated_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!err_evt_i[k] && !clr[k]) |=> $stable(err_cnt[k]));
  end

  rx_byte_counter #(.W(BYTE_W)) u_bytes (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .byte_vld_i (byte_vld_i),
    .sof_i      (sof_i),
    .eof_i      (eof_i),
    .cnt_o      (byte_cnt)
  );

  warn_irq_gen #(.N(NUM_ERR)) u_irq (
    .warn_i (warn),
    .irq_o  (irq_o)
  );

  always_comb begin
    rd_data_o = '0;
    if (rd_sel_i == BYTE_SEL) rd_data_o = byte_cnt;
    for (int k = 0; k < NUM_ERR; k++) begin
      if (rd_sel_i == SEL_W'(k)) rd_data_o = BYTE_W'(err_cnt[k]);
    end
  end

  // irq can only rise after some error event
  p_irq_cause_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(|err_evt_i));
  // a read of the byte counter never disturbs it
  p_byte_rd_keep_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && rd_sel_i == BYTE_SEL && !sof_i && !byte_vld_i) |=> $stable(byte_cnt));
endmodule

// File: tb/rx_stat_counters_bench.sv
module rx_stat_counters_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [2:0]  err_evt = '0;
  logic        byte_vld = 1'b0, sof = 1'b0, eof = 1'b0;
  logic        rd_en = 1'b0;
  logic [1:0]  rd_sel = '0;
  logic [15:0] rd_data;
  logic        irq;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  rx_stat_counters u_rx_stat_counters (
    .clk_i(clk), .rst_ni(rst_ni), .err_evt_i(err_evt), .byte_vld_i(byte_vld),
    .sof_i(sof), .eof_i(eof), .rd_en_i(rd_en), .rd_sel_i(rd_sel),
    .rd_data_o(rd_data), .irq_o(irq));

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] peek(input logic [1:0] s);
    return 16'(0);
  endfunction

  task automatic look(input logic [1:0] s, output logic [15:0] v);
    rd_en = 1'b0; rd_sel = s; #1; v = rd_data;
  endtask

  task automatic rd(input logic [1:0] s, input logic [2:0] evt, output logic [15:0] v);
    rd_sel = s; rd_en = 1'b1; err_evt = evt; #1; v = rd_data;
    @(negedge clk); rd_en = 1'b0; err_evt = '0;
  endtask

  task automatic pulse(input logic [2:0] m, input int n);
    for (int i = 0; i < n; i++) begin
      err_evt = m; @(negedge clk); err_evt = '0;
    end
  endtask

  task automatic bytes(input logic s, input logic e, input logic v, input int n);
    for (int i = 0; i < n; i++) begin
      sof = s; eof = e; byte_vld = v; @(negedge clk);
      sof = 1'b0; eof = 1'b0; byte_vld = 1'b0;
    end
  endtask

  task automatic t_reset;
    logic [15:0] v;
    for (int s = 0; s < 4; s++) begin
      look(2'(s), v); chk("R10 reset value", v, 16'd0);
    end
    chk("R10 reset irq", {15'd0, irq}, 16'd0);
  endtask

  task automatic t_count;
    logic [15:0] v;
    pulse(3'b001, 5);
    look(2'd0, v); chk("R1 five events", v, 16'd5);
    look(2'd1, v); chk("R9 ctr1 untouched", v, 16'd0);
    look(2'd2, v); chk("R9 ctr2 untouched", v, 16'd0);
  endtask

  task automatic t_read_clear;
    logic [15:0] v;
    pulse(3'b010, 2);
    rd(2'd0, 3'b000, v); chk("R3 read value", v, 16'd5);
    look(2'd0, v); chk("R3 cleared after read", v, 16'd0);
    look(2'd1, v); chk("R9 read leaves ctr1", v, 16'd2);
  endtask

  task automatic t_read_evt;
    logic [15:0] v;
    pulse(3'b010, 1);
    rd(2'd1, 3'b010, v); chk("R4 read returns old", v, 16'd3);
    look(2'd1, v); chk("R4 restarts at one", v, 16'd1);
    rd(2'd1, 3'b000, v);
  endtask

  task automatic t_irq;
    logic [15:0] v;
    pulse(3'b100, 191);
    chk("R5 irq low at 191", {15'd0, irq}, 16'd0);
    pulse(3'b100, 1);
    chk("R5 irq high at 192", {15'd0, irq}, 16'd1);
    rd(2'd2, 3'b000, v); chk("R3 read 192", v, 16'd192);
    chk("R5 irq low after read", {15'd0, irq}, 16'd0);
  endtask

  task automatic t_sat;
    logic [15:0] v;
    pulse(3'b001, 300);
    look(2'd0, v); chk("R2 saturated", v, 16'd255);
    chk("R5 irq at saturation", {15'd0, irq}, 16'd1);
    rd(2'd0, 3'b000, v); chk("R2 read saturated", v, 16'd255);
    look(2'd0, v); chk("R3 cleared from 255", v, 16'd0);
  endtask

  task automatic t_multi;
    logic [15:0] v;
    pulse(3'b111, 4);
    for (int s = 0; s < 3; s++) begin
      look(2'(s), v); chk("R9 simultaneous events", v, 16'd4);
    end
  endtask

  task automatic t_bytes;
    logic [15:0] v;
    bytes(1'b0, 1'b0, 1'b1, 3);
    look(2'd3, v); chk("R7 bytes before frame ignored", v, 16'd0);
    bytes(1'b1, 1'b0, 1'b1, 1);
    bytes(1'b0, 1'b0, 1'b1, 9);
    bytes(1'b0, 1'b0, 1'b0, 2);
    bytes(1'b0, 1'b1, 1'b1, 1);
    look(2'd3, v); chk("R6 frame length", v, 16'd11);
    bytes(1'b0, 1'b0, 1'b1, 4);
    look(2'd3, v); chk("R7 held after eof", v, 16'd11);
    rd(2'd3, 3'b000, v); chk("R6 read byte count", v, 16'd11);
    look(2'd3, v); chk("R6 read does not clear", v, 16'd11);
    bytes(1'b1, 1'b0, 1'b1, 1);
    bytes(1'b0, 1'b1, 1'b1, 1);
    look(2'd3, v); chk("R6 second frame", v, 16'd2);
    bytes(1'b1, 1'b1, 1'b1, 1);
    look(2'd3, v); chk("R6 one byte frame", v, 16'd1);
  endtask

  task automatic t_byte_sat;
    logic [15:0] v;
    bytes(1'b1, 1'b0, 1'b1, 1);
    bytes(1'b0, 1'b0, 1'b1, 70000);
    look(2'd3, v); chk("R8 byte saturation", v, 16'd65535);
    bytes(1'b0, 1'b1, 1'b1, 1);
    look(2'd3, v); chk("R8 held at max", v, 16'd65535);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_count();
    t_read_clear();
    t_read_evt();
    t_irq();
    t_sat();
    t_multi();
    t_bytes();
    t_byte_sat();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule